// File: doc/BRIEF.md
# State-Sequenced Counter and Waveform Engine

This block is a timer whose counter can be split into two independent 16-bit halves or joined into one 32-bit counter. The counter advances either on every clock while running or once per rising edge of a chosen external input. Each half counts in one of two ways. In wrap mode it counts up to its limit and then restarts at zero. In bounce mode it climbs to its limit and then descends to zero.

A small set of events watches the counter and the external inputs. An event triggers on a compare match or on an input edge. It acts only when the current value of a two-bit state register appears in its state mask. When it acts it can:
- set or clear waveform outputs,
- load a new state,
- copy the counter into a capture register,
- pulse an interrupt line.

Because the state can change from one counter period to the next, the outputs can follow a pattern that spans several periods. Software configures the block through a write-only word interface.

Top module: `sct_timer`

## Requirements
- R1: After reset the counter, direction, state, outputs, interrupt lines and capture registers are all zero, and the block does not count until the run bit is set.
- R2: Configuration word (address 0) bits: 0 run, 1 unify, 2 bounce for the low half (or the unified counter), 3 bounce for the high half, 4 count on input edges, 5 index of the counting input. With unify 0 and bounce off, each 16-bit half steps once per tick from 0 up to its own limit and then returns to 0.
- R3: In bounce mode a counter rises from 0 to its limit, then falls back to 0 and turns around. The period is twice the limit, and a limit of 0 keeps the counter at 0.
- R4: With unify 1 the full 32-bit counter uses the full 32-bit limit (address 1; in split mode bits 15:0 limit the low half and bits 31:16 the high half), so a carry passes from bit 15 to bit 16 and a borrow passes back.
- R5: When counting on input edges, the counter advances by exactly one for each rising edge of the selected input. The edge takes effect on the third clock edge after the input rises. With run 0 the counter holds.
- R6: Each event has an event control word at address 2+2e and a compare word at 3+2e. Control bits 3:0 are a state mask: the event acts only when mask bit [state] is 1.
- R7: Trigger code (control bits 5:4) 0 selects a compare match. It fires in a tick cycle when the counter equals the compare word: the full 32 bits when unified, otherwise the half chosen by bit 7 (0 low, 1 high) against compare bits 15:0. Its effects are visible after the next clock edge.
- R8: Trigger codes 1, 2 and 3 fire on the rising edge, the falling edge, or either edge of the input chosen by bit 6. They fire in the cycle after the synchronised input changes, and they ignore the other edge.
- R9: Control bits 11:8 set outputs and bits 15:12 clear outputs. When both are requested for one output in the same cycle, clear wins.
- R10: With bit 16 set, the event loads bits 18:17 into the state. When several loading events fire in one cycle, the highest-numbered event wins. The state changes only through such loads.
- R11: With bit 19 set, the event copies the 32-bit counter value of its firing cycle into the capture register chosen by bit 20. The other capture register is unchanged.
- R12: With bit 21 set, the event drives its own interrupt line high for exactly the one cycle after it fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | ADDR_W | Configuration word address |
| wr_data | input | 32 | Configuration write data |
| ev_in | input | 2 | External event and clock inputs (asynchronous) |
| out_o | output | 4 | Waveform outputs |
| irq_o | output | NUM_EV | Per-event interrupt pulses |
| state_o | output | 2 | Current state value |
| cnt_o | output | 32 | Counter value ({high half, low half} in split mode) |
| cap_o | output | 64 | Capture registers, register c at bits 32c+31:32c |

## Verification
The two functions that land on one clock edge are conflicting event actions. Two compare events aim at the same counter value, one on the low half and one on the high half. The first sets two outputs and loads state 1. The second clears one of those outputs and loads state 2. After that edge the bench expects the shared output to read cleared, the other output to read set, and the state to read 2. Interrupt timing, capture contents and the state-gated cycling of outputs across periods are each predicted from the counter position at which the event fires.

// File: rtl/sct_pkg.sv
package sct_pkg;
  localparam int CNT_W  = 32;
  localparam int HALF_W = CNT_W / 2;
  localparam int N_ST   = 4;
  localparam int ST_W   = $clog2(N_ST);
  localparam int N_OUT  = 4;
  localparam int N_IN   = 2;
  localparam int IN_W   = $clog2(N_IN);
  localparam int N_CAP  = 2;
  localparam int CAP_W  = $clog2(N_CAP);

  typedef enum logic [1:0] {
    TRG_MATCH = 2'd0,
    TRG_RISE  = 2'd1,
    TRG_FALL  = 2'd2,
    TRG_EDGE  = 2'd3
  } trig_e;

  // event control word, LSB first: mask, trigger, input, half, set, clr, load, value, cap, sel, irq
  typedef struct packed {
    logic             irq_en;
    logic [CAP_W-1:0] cap_sel;
    logic             cap_en;
    logic [ST_W-1:0]  st_val;
    logic             st_ld;
    logic [N_OUT-1:0] clr;
    logic [N_OUT-1:0] set;
    logic             half;
    logic [IN_W-1:0]  in_sel;
    trig_e            trig;
    logic [N_ST-1:0]  st_mask;
  } ev_ctrl_t;

  typedef struct packed {
    logic [IN_W-1:0] clk_sel;
    logic            clk_in;
    logic            ud_hi;
    logic            ud_lo;
    logic            unify;
    logic            run;
  } cfg_t;

  localparam int EV_W  = $bits(ev_ctrl_t);
  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/sct_step.sv
module sct_step #(
  parameter int W = 16
) (
  input  logic         en,
  input  logic         updown,
  input  logic [W-1:0] lim,
  input  logic [W-1:0] cur,
  input  logic         dir,
  output logic [W-1:0] nxt,
  output logic         nxt_dir
);
  always_comb begin
    nxt     = cur;
    nxt_dir = dir;
    if (en) begin
      if (!updown) begin
        nxt_dir = 1'b0;
        nxt     = (cur >= lim) ? '0 : cur + W'(1);
      end else if (lim == '0) begin
        nxt     = '0;
        nxt_dir = 1'b0;
      end else if (!dir) begin
        if (cur >= lim) begin
          nxt     = cur - W'(1);
          nxt_dir = 1'b1;
        end else begin
          nxt = cur + W'(1);
        end
      end else begin
        if (cur == '0) begin
          nxt     = W'(1);
          nxt_dir = 1'b0;
        end else begin
          nxt = cur - W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sct_insync.sv
module sct_insync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q & ~s3_q;
  assign fall = ~s2_q & s3_q;
endmodule

// File: rtl/sct_event.sv
module sct_event
  import sct_pkg::*;
(
  input  ev_ctrl_t         ctrl,
  input  logic [CNT_W-1:0] match,
  input  logic [CNT_W-1:0] cnt,
  input  logic             unify,
  input  logic             tick,
  input  logic             run,
  input  logic [ST_W-1:0]  state,
  input  logic [N_IN-1:0]  rise,
  input  logic [N_IN-1:0]  fall,
  output logic             fire
);
  logic hit, r, f, cond;

  always_comb begin
    if (unify)          hit = (cnt == match);
    else if (ctrl.half) hit = (cnt[CNT_W-1:HALF_W] == match[HALF_W-1:0]);
    else                hit = (cnt[HALF_W-1:0] == match[HALF_W-1:0]);
    r = rise[ctrl.in_sel];
    f = fall[ctrl.in_sel];
    unique case (ctrl.trig)
      TRG_MATCH: cond = tick & hit;
      TRG_RISE:  cond = run & r;
      TRG_FALL:  cond = run & f;
      default:   cond = run & (r | f);
    endcase
  end

  assign fire = cond & ctrl.st_mask[state];
endmodule

// File: rtl/sct_timer.sv
module sct_timer
  import sct_pkg::*;
#(
  parameter int NUM_EV = 4,
  parameter int ADDR_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [31:0]            wr_data,
  input  logic [N_IN-1:0]        ev_in,
  output logic [N_OUT-1:0]       out_o,
  output logic [NUM_EV-1:0]      irq_o,
  output logic [ST_W-1:0]        state_o,
  output logic [CNT_W-1:0]       cnt_o,
  output logic [N_CAP*CNT_W-1:0] cap_o
);
  cfg_t             cfg_q;
  logic [CNT_W-1:0] lim_q;
  ev_ctrl_t         ev_ctrl_q  [NUM_EV];
  logic [CNT_W-1:0] ev_match_q [NUM_EV];

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dir_lo_q, dir_lo_d, dir_hi_q, dir_hi_d;
  logic [ST_W-1:0]  state_q, state_d;
  logic [N_OUT-1:0] out_q, out_d, set_any, clr_any;
  logic [NUM_EV-1:0] irq_q, irq_d, fire;
  logic [CNT_W-1:0] cap_q [N_CAP];
  logic [CNT_W-1:0] cap_d [N_CAP];

  logic [N_IN-1:0]  rise, fall;
  logic             tick;

  // configuration words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      lim_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(0)) cfg_q <= cfg_t'(wr_data[CFG_W-1:0]);
      if (wr_addr == ADDR_W'(1)) lim_q <= wr_data;
    end
  end

  sct_insync #(.N(N_IN)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ev_in), .rise(rise), .fall(fall)
  );

  assign tick = cfg_q.run & (cfg_q.clk_in ? rise[cfg_q.clk_sel] : 1'b1);

  // counter datapath: two halves and a joined variant
  logic [HALF_W-1:0] lo_nxt, hi_nxt;
  logic [CNT_W-1:0]  full_nxt;
  logic              lo_dir, hi_dir, full_dir;

  sct_step #(.W(HALF_W)) u_lo (
    .en(tick), .updown(cfg_q.ud_lo), .lim(lim_q[HALF_W-1:0]),
    .cur(cnt_q[HALF_W-1:0]), .dir(dir_lo_q), .nxt(lo_nxt), .nxt_dir(lo_dir)
  );
  sct_step #(.W(HALF_W)) u_hi (
    .en(tick), .updown(cfg_q.ud_hi), .lim(lim_q[CNT_W-1:HALF_W]),
    .cur(cnt_q[CNT_W-1:HALF_W]), .dir(dir_hi_q), .nxt(hi_nxt), .nxt_dir(hi_dir)
  );
  sct_step #(.W(CNT_W)) u_full (
    .en(tick), .updown(cfg_q.ud_lo), .lim(lim_q),
    .cur(cnt_q), .dir(dir_lo_q), .nxt(full_nxt), .nxt_dir(full_dir)
  );

  always_comb begin
    if (cfg_q.unify) begin
      cnt_d    = full_nxt;
      dir_lo_d = full_dir;
      dir_hi_d = dir_hi_q;
    end else begin
      cnt_d    = {hi_nxt, lo_nxt};
      dir_lo_d = lo_dir;
      dir_hi_d = hi_dir;
    end
  end

  // events
  for (genvar e = 0; e < NUM_EV; e++) begin : g_ev
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ev_ctrl_q[e]  <= '0;
        ev_match_q[e] <= '0;
      end else if (wr_en) begin
        if (wr_addr == ADDR_W'(2 * e + 2)) ev_ctrl_q[e]  <= ev_ctrl_t'(wr_data[EV_W-1:0]);
        if (wr_addr == ADDR_W'(2 * e + 3)) ev_match_q[e] <= wr_data;
      end
    end

    sct_event u_ev (
      .ctrl(ev_ctrl_q[e]), .match(ev_match_q[e]), .cnt(cnt_q),
      .unify(cfg_q.unify), .tick(tick), .run(cfg_q.run), .state(state_q),
      .rise(rise), .fall(fall), .fire(fire[e])
    );
  end

  // merge actions: later events override loads and captures, clear beats set
  always_comb begin
    set_any = '0;
    clr_any = '0;
    state_d = state_q;
    irq_d   = '0;
    cap_d   = cap_q;
    for (int e = 0; e < NUM_EV; e++) begin
      if (fire[e]) begin
        set_any  = set_any | ev_ctrl_q[e].set;
        clr_any  = clr_any | ev_ctrl_q[e].clr;
        irq_d[e] = ev_ctrl_q[e].irq_en;
        if (ev_ctrl_q[e].st_ld)  state_d = ev_ctrl_q[e].st_val;
        if (ev_ctrl_q[e].cap_en) cap_d[ev_ctrl_q[e].cap_sel] = cnt_q;
      end
    end
    out_d = (out_q | set_any) & ~clr_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      dir_lo_q <= 1'b0;
      dir_hi_q <= 1'b0;
      state_q  <= '0;
      out_q    <= '0;
      irq_q    <= '0;
      for (int c = 0; c < N_CAP; c++) cap_q[c] <= '0;
    end else begin
      cnt_q    <= cnt_d;
      dir_lo_q <= dir_lo_d;
      dir_hi_q <= dir_hi_d;
      state_q  <= state_d;
      out_q    <= out_d;
      irq_q    <= irq_d;
      for (int c = 0; c < N_CAP; c++) cap_q[c] <= cap_d[c];
    end
  end

  assign out_o   = out_q;
  assign irq_o   = irq_q;
  assign state_o = state_q;
  assign cnt_o   = cnt_q;
  for (genvar c = 0; c < N_CAP; c++) begin : g_cap
    assign cap_o[c*CNT_W +: CNT_W] = cap_q[c];
  end
endmodule

// File: rtl/sct_timer_chk.sv
module sct_timer_chk
  import sct_pkg::*;
#(
  parameter int NUM_EV = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  lim_q,
  input logic              unify,
  input logic              ud_lo,
  input logic [NUM_EV-1:0] fire,
  input ev_ctrl_t          ev_ctrl_q [NUM_EV],
  input logic [ST_W-1:0]   state_q,
  input logic [NUM_EV-1:0] irq_o
);
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q)); // R5

  AST_UNIFIED_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && unify && !ud_lo && cnt_q == lim_q) |=> (cnt_q == '0)); // R4

  AST_STATE_BY_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(state_q) |-> $past(|fire)); // R10

  for (genvar e = 0; e < NUM_EV; e++) begin : g_chk
    AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      fire[e] |-> ev_ctrl_q[e].st_mask[state_q]); // R6

    AST_IRQ_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[e] |-> $past(fire[e])); // R12
  end
endmodule

bind sct_timer sct_timer_chk #(.NUM_EV(NUM_EV)) i_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_q(cnt_q), .lim_q(lim_q),
  .unify(cfg_q.unify), .ud_lo(cfg_q.ud_lo), .fire(fire),
  .ev_ctrl_q(ev_ctrl_q), .state_q(state_q), .irq_o(irq_o)
);

// File: tb/test_sct_timer.sv
module test_sct_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  logic [1:0]  ev_in;
  logic [3:0]  out_o;
  logic [3:0]  irq_o;
  logic [1:0]  state_o;
  logic [31:0] cnt_o;
  logic [63:0] cap_o;

  int n_chk = 0;
  int n_err = 0;

  sct_timer i_sct_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ev_in(ev_in), .out_o(out_o), .irq_o(irq_o), .state_o(state_o),
    .cnt_o(cnt_o), .cap_o(cap_o)
  );

  always #2 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ev_in = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  function automatic logic [31:0] cfgw(bit run, bit uni, bit udl, bit udh, bit cin, bit csel);
    return {26'd0, csel, cin, udh, udl, uni, run};
  endfunction

  function automatic logic [31:0] evw(logic [3:0] mask, logic [1:0] trig, bit insel, bit half,
                                      logic [3:0] set, logic [3:0] clr, bit ld, logic [1:0] sv,
                                      bit cap, bit csel, bit irq);
    return {10'd0, irq, csel, cap, sv, ld, clr, set, half, insel, trig, mask};
  endfunction

  function automatic int bounce(int k, int lim);
    int m;
    if (lim == 0) return 0;
    m = k % (2 * lim);
    return (m <= lim) ? m : 2 * lim - m;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 cnt", cnt_o, 0);
    chk("R1 state", 32'(state_o), 0);
    chk("R1 out", 32'(out_o), 0);
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 cap0", cap_o[31:0], 0);
    chk("R1 cap1", cap_o[63:32], 0);
    step(3);
    chk("R1 idle without run", cnt_o, 0);

    // R2 split wrap sweep
    for (int l = 0; l < 5; l++) begin
      for (int h = 0; h < 4; h++) begin
        do_reset();
        wr(4'd1, {16'(h), 16'(l)});
        wr(4'd0, cfgw(1, 0, 0, 0, 0, 0));
        for (int k = 0; k < 24; k++) begin
          chk("R2 low half", 32'(cnt_o[15:0]), 32'(k % (l + 1)));
          chk("R2 high half", 32'(cnt_o[31:16]), 32'(k % (h + 1)));
          step(1);
        end
      end
    end

    // R3 bounce sweep
    for (int l = 0; l < 5; l++) begin
      for (int h = 0; h < 5; h++) begin
        do_reset();
        wr(4'd1, {16'(h), 16'(l)});
        wr(4'd0, cfgw(1, 0, 1, 1, 0, 0));
        for (int k = 0; k < 20; k++) begin
          chk("R3 low half", 32'(cnt_o[15:0]), 32'(bounce(k, l)));
          chk("R3 high half", 32'(cnt_o[31:16]), 32'(bounce(k, h)));
          step(1);
        end
      end
    end

    // R4 unified wrap with small limit
    do_reset();
    wr(4'd1, 32'd5);
    wr(4'd0, cfgw(1, 1, 0, 0, 0, 0));
    step(5);
    chk("R4 unified at limit", cnt_o, 5);
    step(1);
    chk("R4 unified wrap", cnt_o, 0);

    // R4 unified bounce across bit 16
    do_reset();
    wr(4'd1, 32'h0001_0000);
    wr(4'd0, cfgw(1, 1, 1, 0, 0, 0));
    step(65535);
    chk("R4 before carry", cnt_o, 32'h0000_FFFF);
    step(1);
    chk("R4 carry into bit 16", cnt_o, 32'h0001_0000);
    step(1);
    chk("R4 borrow back", cnt_o, 32'h0000_FFFF);
    step(1);
    chk("R4 falling", cnt_o, 32'h0000_FFFE);

    // R5 input-edge clocking
    do_reset();
    wr(4'd1, 32'd7);
    wr(4'd0, cfgw(1, 0, 0, 0, 1, 0));
    step(4);
    chk("R5 no edges no count", cnt_o, 0);
    for (int p = 1; p <= 10; p++) begin
      ev_in[0] = 1'b1;
      step(2);
      chk("R5 not yet counted", 32'(cnt_o[15:0]), 32'((p - 1) % 8));
      step(1);
      chk("R5 one per edge", 32'(cnt_o[15:0]), 32'(p % 8));
      ev_in[0] = 1'b0;
      step(3);
      chk("R5 hold on fall", 32'(cnt_o[15:0]), 32'(p % 8));
    end
    ev_in[1] = 1'b1;
    step(4);
    chk("R5 other input ignored", 32'(cnt_o[15:0]), 2);
    ev_in[1] = 1'b0;
    wr(4'd0, cfgw(0, 0, 0, 0, 1, 0));
    ev_in[0] = 1'b1; step(4); ev_in[0] = 1'b0; step(4);
    chk("R5 run off holds", 32'(cnt_o[15:0]), 2);

    // R7 R9 R12 compare set/clear with interrupt
    do_reset();
    wr(4'd1, 32'd9);
    wr(4'd2, evw(4'hF, 2'd0, 0, 0, 4'b0001, 4'b0000, 0, 0, 0, 0, 1));
    wr(4'd3, 32'd3);
    wr(4'd4, evw(4'hF, 2'd0, 0, 0, 4'b0000, 4'b0001, 0, 0, 0, 0, 0));
    wr(4'd5, 32'd7);
    wr(4'd0, cfgw(1, 0, 0, 0, 0, 0));
    for (int k = 0; k < 30; k++) begin
      chk("R9 set then clear", 32'(out_o[0]), 32'((k >= 4) && (k % 10 >= 4) && (k % 10 <= 7)));
      chk("R12 irq pulse", 32'(irq_o), 32'(((k >= 4) && (k % 10 == 4)) ? 1 : 0));
      step(1);
    end

    // R6 R10 state sequence across periods
    do_reset();
    wr(4'd1, 32'd9);
    wr(4'd2, evw(4'b0001, 2'd0, 0, 0, 4'b0010, 4'b0000, 1, 2'd1, 0, 0, 0));
    wr(4'd3, 32'd2);
    wr(4'd4, evw(4'b0010, 2'd0, 0, 0, 4'b0000, 4'b0010, 1, 2'd2, 0, 0, 0));
    wr(4'd5, 32'd2);
    wr(4'd6, evw(4'b0100, 2'd0, 0, 0, 4'b0000, 4'b0000, 1, 2'd3, 0, 0, 0));
    wr(4'd7, 32'd2);
    wr(4'd8, evw(4'b1000, 2'd0, 0, 0, 4'b0000, 4'b0000, 1, 2'd0, 0, 0, 0));
    wr(4'd9, 32'd2);
    wr(4'd0, cfgw(1, 0, 0, 0, 0, 0));
    for (int k = 0; k < 46; k++) begin
      int es;
      es = (k >= 3) ? (((k - 3) / 10 + 1) % 4) : 0;
      chk("R10 state sequence", 32'(state_o), 32'(es));
      chk("R6 masked output", 32'(out_o[1]), 32'(es == 1));
      step(1);
    end

    // R9 R10 R11 same-cycle conflicts and captures
    do_reset();
    wr(4'd1, {16'd9, 16'd9});
    wr(4'd2, evw(4'hF, 2'd0, 0, 0, 4'b1100, 4'b0000, 1, 2'd1, 1, 0, 0));
    wr(4'd3, 32'd4);
    wr(4'd4, evw(4'hF, 2'd0, 0, 1, 4'b0000, 4'b0100, 1, 2'd2, 0, 0, 0));
    wr(4'd5, 32'd4);
    wr(4'd6, evw(4'b1000, 2'd0, 0, 0, 4'b0000, 4'b0000, 0, 0, 1, 1, 1));
    wr(4'd7, 32'd6);
    wr(4'd8, evw(4'hF, 2'd1, 1, 0, 4'b0000, 4'b0000, 0, 0, 1, 1, 1));
    wr(4'd0, cfgw(1, 0, 0, 0, 0, 0));
    step(5);
    chk("R9 clear wins", 32'(out_o), 32'b1000);
    chk("R10 highest event wins", 32'(state_o), 2);
    chk("R11 capture value", cap_o[31:0], 32'h0004_0004);
    step(2);
    chk("R6 masked capture", cap_o[63:32], 0);
    chk("R6 masked irq", 32'(irq_o[2]), 0);
    begin
      logic [31:0] v;
      // R8 rising edge on input 1
      ev_in[1] = 1'b1;
      step(2);
      v = cnt_o;
      step(1);
      chk("R8 rise capture", cap_o[63:32], v);
      chk("R11 other capture kept", cap_o[31:0], 32'h0004_0004);
      chk("R8 rise irq", 32'(irq_o[3]), 1);
      step(1);
      chk("R12 one cycle", 32'(irq_o[3]), 0);
      // falling trigger
      wr(4'd8, evw(4'hF, 2'd2, 1, 0, 4'b0000, 4'b0000, 0, 0, 1, 1, 1));
      ev_in[1] = 1'b0;
      step(2);
      v = cnt_o;
      step(1);
      chk("R8 fall capture", cap_o[63:32], v);
      chk("R8 fall irq", 32'(irq_o[3]), 1);
      ev_in[1] = 1'b1;
      step(2);
      v = cap_o[63:32];
      step(1);
      chk("R8 rise ignored by fall trigger", 32'(irq_o[3]), 0);
      chk("R8 capture untouched", cap_o[63:32], v);
      // either edge
      wr(4'd8, evw(4'hF, 2'd3, 1, 0, 4'b0000, 4'b0000, 0, 0, 0, 0, 1));
      ev_in[1] = 1'b0;
      step(3);
      chk("R8 either edge fall", 32'(irq_o[3]), 1);
      ev_in[1] = 1'b1;
      step(3);
      chk("R8 either edge rise", 32'(irq_o[3]), 1);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule